// File: doc/BRIEF.md
# Locked Memory-Mapped Register Window

This block puts the 1024 register slots of a trace unit behind a 4 KB memory-mapped window. A requester presents a 12-bit byte address, a write flag, 32-bit write data and one bit that marks the access as coming from a debugger rather than from on-chip software. The block decodes the slot, performs the read or write, and answers with read data and a one-cycle completion strobe.

Software has to unlock the window before its writes take effect. It does so by writing a fixed key to a lock-key register. Debugger accesses are never gated. Software can read the lock state back through a lock-state register. Slots that hold no register read as zero and discard writes. The same rule applies to a read of a write-only slot and to a write to a read-only slot, so every access has a defined result.

The slots this instance implements are as follows. A bank of `NUM_RW` read/write configuration registers starts at slot `RW_BASE` and is driven out on `cfg_out`. One write-only command register sits at slot `WO_NUM` and is driven out on `cmd_out`. One read-only identity register sits at slot `ID_NUM`. The two lock registers complete the set.

Top module: `regport_mmio`

## Requirements
- R1: After reset `rsp_ready` is 0, `cfg_out` and `cmd_out` are all zero, and the window is locked.
- R2: An access is accepted on a rising edge where `req_valid` is 1 and `rsp_ready` is 0. `rsp_ready` is then 1 for exactly the following cycle. Read data is valid in that cycle.
- R3: Slot number is `req_addr[11:2]`, so slot n lives at byte offset 4*n. An access with `req_addr[1:0]` not equal to 0 is treated as unimplemented.
- R4: Reads of unimplemented slots return 0. Writes to them change no output.
- R5: A software write of 0xC5ACCE55 to the lock-key slot 0x3EC (offset 0xFB0) unlocks the window. A software write of any other value to that slot locks it.
- R6: The lock-state slot 0x3ED (offset 0xFB4) reads, for software, bit 0 = 1, bit 1 = 1 while locked, and all other bits 0. For a debugger it reads 0. Writes to it are ignored.
- R7: While locked, software writes to any slot other than the lock-key slot are ignored. Software reads still return data.
- R8: Debugger writes take effect whatever the lock state. Debugger writes to the lock-key slot do not change the lock.
- R9: The command slot `WO_NUM` reads 0. An accepted write to it appears on `cmd_out` from the completion cycle on.
- R10: The identity slot `ID_NUM` reads `ID_VALUE`. Writes to it are ignored.
- R11: The lock-key slot reads 0.
- R12: The configuration slots `RW_BASE`..`RW_BASE+NUM_RW-1` read back the last accepted write. Slot `RW_BASE+i` drives `cfg_out[32*i+31:32*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, held until `rsp_ready` |
| req_addr | input | 12 | Byte address in the window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_dbg | input | 1 | 1 = debugger access, 0 = software access |
| rsp_ready | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` |
| cfg_out | output | NUM_RW*32 | Contents of the configuration bank |
| cmd_out | output | 32 | Contents of the command register |

## Verification
The bench builds the block with four configuration slots at slot 4, the command slot at 1 and the identity slot at 0x079. This small map lets each phase sweep all 1024 slot numbers, for reads and for writes, from both requester types. Slots are also addressed with non-zero low address bits. Every slot type therefore meets every lock state, and the bench computes each expected read from a slot-number formula.

// File: rtl/regport_pkg.sv
package regport_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned SLOT_W = 10;

    localparam logic [SLOT_W-1:0] KEY_SLOT   = 10'h3EC;
    localparam logic [SLOT_W-1:0] STATE_SLOT = 10'h3ED;
    localparam logic [DATA_W-1:0] OPEN_KEY   = 32'hC5AC_CE55;

    typedef enum logic [2:0] {
        SK_NONE,
        SK_CFG,
        SK_ID,
        SK_CMD,
        SK_KEY,
        SK_STATE
    } slot_kind_e;

    typedef struct packed {
        logic              write;
        logic              dbg;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] state_word(input logic locked);
        return {{(DATA_W-2){1'b0}}, locked, 1'b1};
    endfunction

endpackage

// File: rtl/regport_decode.sv
module regport_decode
    import regport_pkg::*;
#(
    parameter int unsigned NUM_RW  = 4,
    parameter int unsigned RW_BASE = 4,
    parameter int unsigned WO_NUM  = 1,
    parameter int unsigned ID_NUM  = 121,
    parameter int unsigned IDX_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output slot_kind_e        kind,
    output logic [IDX_W-1:0]  cfg_idx
);
    localparam logic [SLOT_W:0]   LO_L  = (SLOT_W+1)'(RW_BASE);
    localparam logic [SLOT_W:0]   HI_L  = (SLOT_W+1)'(RW_BASE + NUM_RW);
    localparam logic [SLOT_W-1:0] WO_L  = SLOT_W'(WO_NUM);
    localparam logic [SLOT_W-1:0] ID_L  = SLOT_W'(ID_NUM);

    logic [SLOT_W-1:0] slot;
    logic              aligned;
    logic [SLOT_W:0]   rel;

    assign slot    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign rel     = {1'b0, slot} - LO_L;
    assign cfg_idx = rel[IDX_W-1:0];

    always_comb begin
        kind = SK_NONE;
        if (aligned) begin
            if ({1'b0, slot} >= LO_L && {1'b0, slot} < HI_L) kind = SK_CFG;
            else if (slot == ID_L)       kind = SK_ID;
            else if (slot == WO_L)       kind = SK_CMD;
            else if (slot == KEY_SLOT)   kind = SK_KEY;
            else if (slot == STATE_SLOT) kind = SK_STATE;
        end
    end

endmodule

// File: rtl/regport_lock.sv
module regport_lock
    import regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              locked
);
    always_ff @(posedge clk) begin
        if (rst)         locked <= 1'b1;
        else if (key_wr) locked <= (key_data != OPEN_KEY);
    end
endmodule

// File: rtl/regport_bank.sv
module regport_bank
    import regport_pkg::*;
#(
    parameter int unsigned NUM_RW = 4,
    parameter int unsigned IDX_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [IDX_W-1:0]         idx,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic [NUM_RW*DATA_W-1:0] flat
);
    logic [DATA_W-1:0] slot_q [NUM_RW];

    for (genvar g = 0; g < NUM_RW; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                             slot_q[g] <= '0;
            else if (we && idx == IDX_W'(g))     slot_q[g] <= wdata;
        end
        assign flat[g*DATA_W +: DATA_W] = slot_q[g];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_RW; i++)
            if (idx == IDX_W'(i)) rdata = slot_q[i];
    end
endmodule

// File: rtl/regport_mmio.sv
module regport_mmio
    import regport_pkg::*;
#(
    parameter int unsigned NUM_RW   = 4,
    parameter int unsigned RW_BASE  = 4,
    parameter int unsigned WO_NUM   = 1,
    parameter int unsigned ID_NUM   = 121,
    parameter logic [31:0] ID_VALUE = 32'h4D50_0A11
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [11:0]              req_addr,
    input  logic                     req_write,
    input  logic [31:0]              req_wdata,
    input  logic                     req_dbg,
    output logic                     rsp_ready,
    output logic [31:0]              rsp_rdata,
    output logic [NUM_RW*32-1:0]     cfg_out,
    output logic [31:0]              cmd_out
);
    localparam int unsigned IDX_W = (NUM_RW > 1) ? $clog2(NUM_RW) : 1;

    bus_req_t          req;
    slot_kind_e        kind;
    logic [IDX_W-1:0]  cfg_idx;
    logic [DATA_W-1:0] bank_rd;
    logic [DATA_W-1:0] rd_mux;
    logic              locked_q;
    logic              accept;
    logic              wr_go;
    logic              key_wr;

    assign req = '{write: req_write, dbg: req_dbg, addr: req_addr, wdata: req_wdata};

    regport_decode #(
        .NUM_RW(NUM_RW), .RW_BASE(RW_BASE), .WO_NUM(WO_NUM),
        .ID_NUM(ID_NUM), .IDX_W(IDX_W)
    ) u_dec (
        .addr(req.addr), .kind(kind), .cfg_idx(cfg_idx)
    );

    assign accept = req_valid && !rsp_ready;
    assign wr_go  = accept && req.write && (req.dbg || !locked_q);
    assign key_wr = accept && req.write && !req.dbg && (kind == SK_KEY);

    regport_lock u_lock (
        .clk(clk), .rst(rst), .key_wr(key_wr),
        .key_data(req.wdata), .locked(locked_q)
    );

    regport_bank #(.NUM_RW(NUM_RW), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst),
        .we(wr_go && kind == SK_CFG),
        .idx(cfg_idx), .wdata(req.wdata),
        .rdata(bank_rd), .flat(cfg_out)
    );

    always_comb begin
        unique case (kind)
            SK_CFG:   rd_mux = bank_rd;
            SK_ID:    rd_mux = ID_VALUE;
            SK_STATE: rd_mux = req.dbg ? '0 : state_word(locked_q);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_ready <= 1'b0;
            rsp_rdata <= '0;
            cmd_out   <= '0;
        end else begin
            rsp_ready <= accept;
            if (accept)                   rsp_rdata <= req.write ? '0 : rd_mux;
            if (wr_go && kind == SK_CMD)  cmd_out   <= req.wdata;
        end
    end

endmodule

// File: rtl/regport_mmio_chk.sv
module regport_mmio_chk
    import regport_pkg::*;
#(
    parameter int unsigned CFG_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [11:0]      req_addr,
    input logic             req_write,
    input logic [31:0]      req_wdata,
    input logic             req_dbg,
    input logic             rsp_ready,
    input logic [31:0]      rsp_rdata,
    input logic [CFG_W-1:0] cfg_out,
    input logic [31:0]      cmd_out,
    input logic             locked_q
);
    logic             acc;
    logic             on_slot_key;
    logic             on_slot_state;

    assign acc           = req_valid && !rsp_ready;
    assign on_slot_key   = (req_addr == {KEY_SLOT, 2'b00});
    assign on_slot_state = (req_addr == {STATE_SLOT, 2'b00});

    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_ready && locked_q && cfg_out == '0 && cmd_out == '0));

    // R2
    a_r2_ready_single: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |=> !rsp_ready);

    a_r2_ready_after_valid: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |-> $past(req_valid));

    // R5
    a_r5_key_unlocks: assert property (@(posedge clk) disable iff (rst)
        (acc && req_write && !req_dbg && on_slot_key && req_wdata == OPEN_KEY) |=> !locked_q);

    a_r5_bad_key_locks: assert property (@(posedge clk) disable iff (rst)
        (acc && req_write && !req_dbg && on_slot_key && req_wdata != OPEN_KEY) |=> locked_q);

    // R6
    a_r6_dbg_state_zero: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_write && req_dbg && on_slot_state) |=> rsp_rdata == 32'h0);

    a_r6_sw_state_word: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_write && !req_dbg && on_slot_state)
            |=> rsp_rdata == {30'h0, $past(locked_q), 1'b1});

    // R7
    a_r7_locked_sw_blocked: assert property (@(posedge clk) disable iff (rst)
        (acc && req_write && !req_dbg && locked_q && !on_slot_key)
            |=> ($stable(cfg_out) && $stable(cmd_out)));

    // R8
    a_r8_dbg_keeps_lock: assert property (@(posedge clk) disable iff (rst)
        (acc && req_dbg) |=> $stable(locked_q));

endmodule

bind regport_mmio regport_mmio_chk #(.CFG_W(NUM_RW*32)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_dbg(req_dbg),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .cfg_out(cfg_out),
    .cmd_out(cmd_out), .locked_q(locked_q)
);

// File: tb/sim_regport_mmio.sv
module sim_regport_mmio;
    localparam int          NRW   = 4;
    localparam int          BASE  = 4;
    localparam int          WON   = 1;
    localparam int          IDN   = 121;
    localparam logic [31:0] IDV   = 32'h4D50_0A11;
    localparam int          KEYN  = 12'h3EC;
    localparam int          STN   = 12'h3ED;
    localparam logic [31:0] KEY   = 32'hC5AC_CE55;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [11:0]       req_addr = '0;
    logic              req_write = 1'b0;
    logic [31:0]       req_wdata = '0;
    logic              req_dbg = 1'b0;
    logic              rsp_ready;
    logic [31:0]       rsp_rdata;
    logic [NRW*32-1:0] cfg_out;
    logic [31:0]       cmd_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] cfg_m [NRW];
    logic [31:0] cmd_m;
    bit          lock_m;

    always #5 clk = ~clk;

    regport_mmio #(
        .NUM_RW(NRW), .RW_BASE(BASE), .WO_NUM(WON), .ID_NUM(IDN), .ID_VALUE(IDV)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_dbg(req_dbg),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .cfg_out(cfg_out),
        .cmd_out(cmd_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int n, input bit dbg);
        if (n >= BASE && n < BASE + NRW) return cfg_m[n - BASE];
        if (n == IDN) return IDV;
        if (n == STN) return dbg ? 32'h0 : {30'h0, lock_m, 1'b1};
        return 32'h0;
    endfunction

    function automatic void model_wr(input int n, input bit dbg, input logic [31:0] d);
        if (n == KEYN) begin
            if (!dbg) lock_m = (d != KEY);
            return;
        end
        if (!dbg && lock_m) return;
        if (n >= BASE && n < BASE + NRW) cfg_m[n - BASE] = d;
        if (n == WON) cmd_m = d;
    endfunction

    function automatic logic [31:0] pat(input int n, input int seed);
        return 32'(n) * 32'h9E37_79B1 ^ 32'(seed);
    endfunction

    // One access; R2 timing is checked on every transfer.
    task automatic xfer(input logic [11:0] a, input bit wr, input bit dbg,
                        input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        chk(rsp_ready == 1'b0, "R2 idle before request", 32'(rsp_ready), 32'h0);
        req_addr = a; req_write = wr; req_dbg = dbg; req_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        chk(rsp_ready == 1'b1, "R2 ready one cycle after valid", 32'(rsp_ready), 32'h1);
        rd = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic chk_outs(input string tag);
        for (int i = 0; i < NRW; i++)
            chk(cfg_out[i*32 +: 32] === cfg_m[i], tag, cfg_out[i*32 +: 32], cfg_m[i]);
        chk(cmd_out === cmd_m, tag, cmd_out, cmd_m);
    endtask

    task automatic read_sweep(input bit dbg, input string tag);
        logic [31:0] rd;
        for (int n = 0; n < 1024; n++) begin
            xfer(12'(n * 4), 1'b0, dbg, 32'h0, rd);
            chk(rd === exp_rd(n, dbg), tag, rd, exp_rd(n, dbg));
        end
    endtask

    task automatic write_sweep(input bit dbg, input int seed, input string tag);
        logic [31:0] rd;
        for (int n = 0; n < 1024; n++) begin
            if (n == KEYN) continue;
            xfer(12'(n * 4), 1'b1, dbg, pat(n, seed), rd);
            model_wr(n, dbg, pat(n, seed));
        end
        chk_outs(tag);
    endtask

    initial begin
        logic [31:0] rd;
        for (int i = 0; i < NRW; i++) cfg_m[i] = '0;
        cmd_m = '0; lock_m = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1
        chk(rsp_ready == 1'b0, "R1 ready low after reset", 32'(rsp_ready), 32'h0);
        chk_outs("R1 outputs zero after reset");
        xfer(12'hFB4, 1'b0, 1'b0, 32'h0, rd);
        chk(rd === 32'h3, "R1 R6 locked after reset", rd, 32'h3);

        // R2: held valid gives ready, then a gap, then ready again
        @(negedge clk);
        req_addr = 12'(IDN * 4); req_write = 1'b0; req_dbg = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        chk(rsp_ready == 1'b1, "R2 first strobe", 32'(rsp_ready), 32'h1);
        @(negedge clk);
        chk(rsp_ready == 1'b0, "R2 strobe lasts one cycle", 32'(rsp_ready), 32'h0);
        @(negedge clk);
        chk(rsp_ready == 1'b1, "R2 held valid re-accepted", 32'(rsp_ready), 32'h1);
        chk(rsp_rdata === IDV, "R10 identity read", rsp_rdata, IDV);
        req_valid = 1'b0;

        // R7: locked software reads work, writes are dropped
        read_sweep(1'b0, "R7 R4 R10 R11 locked software read");
        write_sweep(1'b0, 11, "R7 locked software writes ignored");
        read_sweep(1'b0, "R7 R12 bank unchanged while locked");

        // R5: wrong key keeps lock, right key opens
        xfer(12'hFB0, 1'b1, 1'b0, KEY ^ 32'h1, rd); model_wr(KEYN, 1'b0, KEY ^ 32'h1);
        xfer(12'hFB4, 1'b0, 1'b0, 32'h0, rd);
        chk(rd === 32'h3, "R5 wrong key leaves locked", rd, 32'h3);
        xfer(12'hFB0, 1'b1, 1'b0, KEY, rd); model_wr(KEYN, 1'b0, KEY);
        xfer(12'hFB4, 1'b0, 1'b0, 32'h0, rd);
        chk(rd === 32'h1, "R5 R6 key unlocks", rd, 32'h1);
        xfer(12'hFB0, 1'b0, 1'b0, 32'h0, rd);
        chk(rd === 32'h0, "R11 key slot reads zero", rd, 32'h0);

        // Unlocked software: R9 R10 R12 R4 R6
        write_sweep(1'b0, 22, "R9 R12 R4 unlocked software writes");
        chk(cmd_out === pat(WON, 22), "R9 command on cmd_out", cmd_out, pat(WON, 22));
        read_sweep(1'b0, "R9 R10 R12 R4 R6 unlocked read");

        // R3: misaligned addresses act as unimplemented
        for (int n = 0; n < 1024; n++) begin
            if (n == KEYN) continue;
            xfer(12'(n * 4 + 1 + (n % 3)), 1'b1, 1'b0, 32'hDEAD_0000 | 32'(n), rd);
            xfer(12'(n * 4 + 1 + ((n + 1) % 3)), 1'b0, 1'b0, 32'h0, rd);
            chk(rd === 32'h0, "R3 misaligned read zero", rd, 32'h0);
        end
        chk_outs("R3 misaligned writes ignored");
        xfer(12'hFB1, 1'b1, 1'b0, 32'h0, rd);
        xfer(12'hFB4, 1'b0, 1'b0, 32'h0, rd);
        chk(rd === 32'h1, "R3 misaligned key write ignored", rd, 32'h1);

        // R5: any other value relocks
        xfer(12'hFB0, 1'b1, 1'b0, 32'h0, rd); model_wr(KEYN, 1'b0, 32'h0);
        xfer(12'hFB4, 1'b0, 1'b0, 32'h0, rd);
        chk(rd === 32'h3, "R5 other value relocks", rd, 32'h3);

        // R8: debugger bypasses lock and cannot move it
        xfer(12'hFB0, 1'b1, 1'b1, KEY, rd); model_wr(KEYN, 1'b1, KEY);
        xfer(12'hFB4, 1'b0, 1'b0, 32'h0, rd);
        chk(rd === 32'h3, "R8 debugger key write no effect", rd, 32'h3);
        write_sweep(1'b1, 33, "R8 debugger writes while locked");
        chk(cfg_out[31:0] === pat(BASE, 33), "R8 R12 debugger bank write", cfg_out[31:0], pat(BASE, 33));
        read_sweep(1'b1, "R6 R8 debugger read sweep");
        xfer(12'hFB4, 1'b0, 1'b0, 32'h0, rd);
        chk(rd === 32'h3, "R6 software still locked", rd, 32'h3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule